// File: doc/BRIEF.md
# Programmable Hysteretic Threshold Switch

This block turns a stream of digitized field-strength samples into a single switch bit with hysteresis. A six-bit calibration code selects the operate threshold as one of 64 equal steps above a parameterized minimum. The release threshold always lies a constant hysteresis below the operate threshold. Only the calibration code moves the thresholds; the gap between them never changes.

Samples arrive on a valid/ready input. The block always accepts, so `s_ready` is held high. A sample counts only in a cycle where `s_valid` is high, and the switch can change state only on such a cycle. A static parameter picks the output polarity. In the inverting variant the output is driven low while the switch is operated. In the non-inverting variant it is driven high. The same parameter fixes the level the output takes out of reset. Only positive (south) field values can operate the switch.

Top module: `hyst_switch`

## Requirements
- R1: Out of reset the inverting variant (`INVERT`=1) drives `sw_out` high and the non-inverting variant (`INVERT`=0) drives it low.
- R2: The operate threshold equals `OP_MIN + cal_code*STEP`, with `cal_code` read as unsigned 0..63 (defaults `OP_MIN`=200, `STEP`=10). The release threshold equals that value minus `HYS` (default 50).
- R3: An accepted sample strictly greater than the operate threshold operates the switch. The output changes on the clock edge that accepts the sample: low for the inverting variant, high for the non-inverting one.
- R4: An accepted sample strictly less than the release threshold releases the switch. The output changes on the clock edge that accepts the sample: high for the inverting variant, low for the non-inverting one.
- R5: An accepted sample within the release and operate thresholds, both ends included, leaves the switch state unchanged.
- R6: When `s_valid` is low, the sample has no effect and the switch state is unchanged.
- R7: `s_ready` is high in every cycle after reset. The block never applies back-pressure, and a sample is taken on every cycle with `s_valid` high.
- R8: A negative (north) sample never operates the switch, because it always lies below the release threshold and so releases the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Always-ready acceptance flag |
| s_sample | input | 12 | Signed two's-complement field sample |
| cal_code | input | 6 | Operate-point calibration code |
| sw_out | output | 1 | Switch output, polarity per `INVERT` |

## Verification
Exact-boundary samples are the hardest case to reach from the ports. A sample equal to either threshold must hold the state, and the result depends on the direction from which the sweep arrives. The bench steps the field one count at a time through `op-1`, `op`, `op+1`, `rp`, `rp-1` for several codes, upward and downward, so each equality is reached from both the operated and the released state. Two instances with opposite `INVERT` settings receive the same stimulus, so both polarity mappings are compared in the same cycle.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic {SW_RELEASED = 1'b0, SW_OPERATED = 1'b1} sw_state_e;
endpackage

// File: rtl/hsw_thresholds.sv
module hsw_thresholds #(
  parameter int SAMPLE_W = 12,
  parameter int CODE_W   = 6,
  parameter int OP_MIN   = 200,
  parameter int STEP     = 10,
  parameter int HYS      = 50,
  localparam int THR_W   = SAMPLE_W + 1
) (
  input  logic [CODE_W-1:0]       code,
  output logic signed [THR_W-1:0] op_thr,
  output logic signed [THR_W-1:0] rp_thr
);
  logic signed [THR_W-1:0] base_v, step_v, hys_v, code_v;

  always_comb begin
    base_v = THR_W'(OP_MIN);
    step_v = THR_W'(STEP);
    hys_v  = THR_W'(HYS);
    code_v = THR_W'(code);
    op_thr = base_v + code_v * step_v;
    rp_thr = op_thr - hys_v;
  end
endmodule

// File: rtl/hsw_state.sv
module hsw_state
  import hsw_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  localparam int THR_W   = SAMPLE_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       take,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [THR_W-1:0]    op_thr,
  input  logic signed [THR_W-1:0]    rp_thr,
  output sw_state_e                  state
);
  logic signed [THR_W-1:0] smp_x;
  logic above_op, below_rp;
  sw_state_e state_nx;

  always_comb begin
    smp_x    = THR_W'(sample);
    above_op = smp_x > op_thr;
    below_rp = smp_x < rp_thr;
    state_nx = state;
    if (take) begin
      if (above_op)      state_nx = SW_OPERATED;
      else if (below_rp) state_nx = SW_RELEASED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SW_RELEASED;
    else        state <= state_nx;
  end

  p_operate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (THR_W'(sample) > op_thr)) |=> (state == SW_OPERATED));
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (THR_W'(sample) < rp_thr)) |=> (state == SW_RELEASED));
  p_band_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (THR_W'(sample) <= op_thr) && (THR_W'(sample) >= rp_thr)) |=> $stable(state));
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(state));
  p_north_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sample[SAMPLE_W-1]) |=> (state == SW_RELEASED));
endmodule

// File: rtl/hsw_drive.sv
module hsw_drive
  import hsw_pkg::*;
#(
  parameter bit INVERT = 1'b1
) (
  input  sw_state_e state,
  output logic      pin
);
  generate
    if (INVERT) begin : g_inv
      assign pin = (state == SW_RELEASED);
    end else begin : g_pass
      assign pin = (state == SW_OPERATED);
    end
  endgenerate
endmodule

// File: rtl/hyst_switch.sv
module hyst_switch
  import hsw_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int CODE_W   = 6,
  parameter int OP_MIN   = 200,
  parameter int STEP     = 10,
  parameter int HYS      = 50,
  parameter bit INVERT   = 1'b1,
  localparam int THR_W   = SAMPLE_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic signed [SAMPLE_W-1:0] s_sample,
  input  logic [CODE_W-1:0]          cal_code,
  output logic                       sw_out
);
  logic signed [THR_W-1:0] op_thr, rp_thr;
  sw_state_e state;
  logic take;

  assign s_ready = 1'b1;
  assign take    = s_valid & s_ready;

  hsw_thresholds #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .OP_MIN(OP_MIN),
                   .STEP(STEP), .HYS(HYS)) u_thr (
    .code(cal_code), .op_thr(op_thr), .rp_thr(rp_thr));

  hsw_state #(.SAMPLE_W(SAMPLE_W)) u_state (
    .clk(clk), .rst_n(rst_n), .take(take), .sample(s_sample),
    .op_thr(op_thr), .rp_thr(rp_thr), .state(state));

  hsw_drive #(.INVERT(INVERT)) u_drive (.state(state), .pin(sw_out));

  p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |-> s_ready);
  p_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_thr - rp_thr) == THR_W'(HYS));
  p_pol_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sw_out == INVERT));
endmodule

// File: tb/hyst_switch_bench.sv
module hyst_switch_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic signed [11:0] s_sample = '0;
  logic [5:0] cal_code = '0;
  logic rdy_i, rdy_n, out_i, out_n;
  int checks = 0;
  int errors = 0;
  bit exp_op = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hyst_switch #(.INVERT(1'b1)) u_hyst_switch (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(rdy_i),
    .s_sample(s_sample), .cal_code(cal_code), .sw_out(out_i));

  hyst_switch #(.INVERT(1'b0)) u_hyst_switch_ni (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(rdy_n),
    .s_sample(s_sample), .cal_code(cal_code), .sw_out(out_n));

  function automatic int op_of(int c);
    return 200 + c * 10;
  endfunction

  task automatic check(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic check_outs(string tag);
    check({tag, " inverting"}, out_i, !exp_op);
    check({tag, " non-inverting"}, out_n, exp_op);
  endtask

  task automatic feed(int v, string tag);
    @(negedge clk);
    s_sample = 12'(v);
    s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    check_outs(tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    exp_op = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset inverting high", out_i, 1'b1);
    check("R1 reset non-inverting low", out_n, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 ready inv", rdy_i, 1'b1);
    check("R7 ready ni", rdy_n, 1'b0 | 1'b1);
  endtask

  task automatic t_sweep(int c);
    int op, rp;
    cal_code = 6'(c);
    op = op_of(c);
    rp = op - 50;
    feed(rp - 20, "R4 start released");
    exp_op = 1'b0;
    feed(op - 1, "R5 below op holds released");
    feed(op, "R5 at op holds released R2");
    exp_op = 1'b1;
    feed(op + 1, "R3 above op operates R2");
    feed(op, "R5 at op holds operated");
    feed(rp, "R5 at rp holds operated");
    exp_op = 1'b0;
    feed(rp - 1, "R4 below rp releases R2");
    feed(rp, "R5 at rp holds released");
  endtask

  task automatic t_idle();
    exp_op = 1'b1;
    feed(2000, "R3 large field operates");
    @(negedge clk);
    s_sample = -12'sd500;
    repeat (3) @(negedge clk);
    check_outs("R6 no valid no release");
    s_valid = 1'b0;
    s_sample = 12'sd2000;
    exp_op = 1'b0;
    feed(0, "R4 zero field releases");
    @(negedge clk);
    repeat (3) @(negedge clk);
    check_outs("R6 no valid no operate");
  endtask

  task automatic t_north();
    cal_code = 6'd0;
    exp_op = 1'b0;
    feed(-2048, "R8 strongest north no operate");
    feed(-1, "R8 weak north no operate");
    exp_op = 1'b1;
    feed(2047, "R3 operate before north");
    exp_op = 1'b0;
    feed(-300, "R8 north releases");
  endtask

  task automatic t_back_to_back();
    cal_code = 6'd10;
    @(negedge clk);
    s_valid = 1'b1;
    s_sample = 12'sd301;
    @(negedge clk);
    exp_op = 1'b1;
    check_outs("R7 first of burst");
    s_sample = 12'sd249;
    @(negedge clk);
    exp_op = 1'b0;
    check_outs("R7 second of burst");
    s_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_sweep(0);
    t_sweep(17);
    t_sweep(63);
    t_idle();
    t_north();
    t_back_to_back();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule